// File: doc/BRIEF.md
# Multi-Channel Match-Compare Timer

This peripheral holds a set of independent up-counters. Each counter has its own bank of match comparators, and all of them sit behind a single-cycle register bus. When a counter reaches the value programmed into one of its comparators, that comparator's status bit sets. Each timer has one interrupt line: the OR of its status bits after each bit is gated by its enable. Software reads a counter by writing a trigger to that timer's capture register. The captured value can be read once a two-stage pipeline has settled.

Each timer restarts in one of two ways. In periodic mode it returns to zero when it matches comparator 0. In free-running mode it wraps from all-ones to zero. Clearing a timer's enable bit also clears its count, so the next enable starts a fresh interval from zero.

Timers are numbered t = 0 to NUM_TMR-1 and comparators c = 0 to NUM_CMP-1.

The bus uses word addresses.

Shared registers:
- 0x00: run enables.
- 0x01: free-run overrides.
- 0x02: capture-valid flags (read-only).

Timer t occupies a block based at 16*(t+1):
- +0: restart control.
- +1: comparator interrupt enables.
- +2: status (write-one-to-clear).
- +3: capture.
- +4+c: match value of comparator c.

In every shared register, bit t belongs to timer t. In every per-timer mask register, bit c belongs to comparator c.

Top module: `mct_timer`

## Requirements
- R1: After reset the enable, override, restart-control, interrupt-enable, status and capture-valid registers read zero. Every match register reads all-ones and every irq output is low.
- R2: While bit t of 0x00 is 1, counter t advances by one per clock. While that bit is 0, the counter is held at zero. A capture taken after the disable therefore reads 0.
- R3: Counter t is enabled from zero by a write at clock edge E0, with comparator c holding N-1. Status bit c sets at edge E0+N and not before.
- R4: When restart control bit 0 is 1 and override bit t is 0, the timer is periodic. It returns to zero on the edge after its count equals comparator 0, so its period is match+1 clocks.
- R5: When override bit t is 1, or restart control is 0, the timer is free-running. It wraps from all-ones to zero, and its comparators still set status whenever the count equals their match value.
- R6: Writing to +2 clears every status bit whose write-data bit is 1. Reading +2 returns the status. A match in the same cycle as a clear leaves the bit set.
- R7: irq[t] is high when any status bit of timer t is set and the corresponding bit of +1 is 1. With +1 at 0, a set status bit leaves irq[t] low.
- R8: A write of any value to +3 at edge E latches the count held just before E. Bit t of 0x02 drops at E and rises at E+1. From E+1 a read of +3 returns the latched value.
- R9: Writes to 0x02 or to any unmapped address change nothing. Reads of unmapped addresses return zero.
- R10: Each timer's count, status, capture and irq are unaffected by the registers of the other timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | CNT_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | CNT_W | Combinational read data for bus_addr |
| irq | output | NUM_TMR | Masked match interrupt, one per timer |

## Verification
The bench builds the block with CNT_W = 8 and keeps three timers of three comparators each. The narrow counter puts the all-ones-to-zero wrap of a free-running timer within a few hundred cycles, so wraparound matches at 0xFF and 0x00 are exercised alongside short periodic intervals. A 5-clock period is co-prime with the 2-cycle write-then-read loop, so repeated clears fall on every phase of the match, including the cycle where a clear meets a new match.

// File: rtl/mct_pkg.sv
package mct_pkg;
  // shared register word addresses
  localparam int GLB_ENABLE = 0;
  localparam int GLB_FREE   = 1;
  localparam int GLB_CAPV   = 2;

  // per-timer block layout
  localparam int CH_STRIDE  = 16;
  localparam int CH_RESTART = 0;
  localparam int CH_IER     = 1;
  localparam int CH_STATUS  = 2;
  localparam int CH_CAPTURE = 3;
  localparam int CH_MATCH0  = 4;

  function automatic int ch_base(input int t);
    return (t + 1) * CH_STRIDE;
  endfunction
endpackage

// File: rtl/mct_counter.sv
module mct_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || restart)  cnt <= '0;
    else                       cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/mct_cmp_bank.sv
module mct_cmp_bank #(
  parameter int CNT_W   = 32,
  parameter int NUM_CMP = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            run,
  input  logic [CNT_W-1:0]                cnt,
  input  logic [CNT_W-1:0]                wdata,
  input  logic [NUM_CMP-1:0]              match_we,
  input  logic                            ier_we,
  input  logic                            clr_we,
  output logic [NUM_CMP-1:0][CNT_W-1:0]   match_q,
  output logic [NUM_CMP-1:0]              ier_q,
  output logic [NUM_CMP-1:0]              status_q,
  output logic [NUM_CMP-1:0]              hit,
  output logic                            irq
);
  logic [NUM_CMP-1:0] clr_mask;

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           match_q[c] <= '1;
      else if (match_we[c]) match_q[c] <= wdata;
    end
    assign hit[c] = run && (cnt == match_q[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ier_q <= '0;
    else if (ier_we) ier_q <= wdata[NUM_CMP-1:0];
  end

  assign clr_mask = clr_we ? wdata[NUM_CMP-1:0] : '0;

  // a fresh match outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_mask) | hit;
  end

  assign irq = |(status_q & ier_q);
endmodule

// File: rtl/mct_capture.sv
module mct_capture #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_valid
);
  logic [CNT_W-1:0] stage1;
  logic             stage1_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1    <= '0;
      stage1_v  <= 1'b0;
      cap_val   <= '0;
      cap_valid <= 1'b0;
    end else begin
      stage1_v <= trig;
      if (trig) stage1 <= cnt;
      if (stage1_v) begin
        cap_val   <= stage1;
        cap_valid <= 1'b1;
      end
      if (trig) cap_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mct_timer.sv
module mct_timer
  import mct_pkg::*;
#(
  parameter int NUM_TMR = 3,
  parameter int NUM_CMP = 3,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_TMR-1:0] irq
);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(GLB_ENABLE);
  localparam logic [ADDR_W-1:0] A_FREE   = ADDR_W'(GLB_FREE);
  localparam logic [ADDR_W-1:0] A_CAPV   = ADDR_W'(GLB_CAPV);

  logic [NUM_TMR-1:0]                            en_q;
  logic [NUM_TMR-1:0]                            free_q;
  logic [NUM_TMR-1:0]                            restart_q;
  logic [NUM_TMR-1:0]                            periodic;
  logic [NUM_TMR-1:0][CNT_W-1:0]                 cnt;
  logic [NUM_TMR-1:0][NUM_CMP-1:0]               hit;
  logic [NUM_TMR-1:0][NUM_CMP-1:0]               status;
  logic [NUM_TMR-1:0][NUM_CMP-1:0]               ier;
  logic [NUM_TMR-1:0][NUM_CMP-1:0][CNT_W-1:0]    match;
  logic [NUM_TMR-1:0][CNT_W-1:0]                 cap_val;
  logic [NUM_TMR-1:0]                            cap_valid;
  logic [NUM_TMR-1:0]                            cap_trig;

  // shared control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      free_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_ENABLE) en_q   <= bus_wdata[NUM_TMR-1:0];
      if (bus_addr == A_FREE)   free_q <= bus_wdata[NUM_TMR-1:0];
    end
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(ch_base(t) + CH_RESTART);
    localparam logic [ADDR_W-1:0] A_IER = ADDR_W'(ch_base(t) + CH_IER);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(ch_base(t) + CH_STATUS);
    localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(ch_base(t) + CH_CAPTURE);

    logic [NUM_CMP-1:0] match_we;

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_mwe
      assign match_we[c] = bus_we && (bus_addr == ADDR_W'(ch_base(t) + CH_MATCH0 + c));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            restart_q[t] <= 1'b0;
      else if (bus_we && bus_addr == A_RST)  restart_q[t] <= bus_wdata[0];
    end

    assign periodic[t] = restart_q[t] && !free_q[t];
    assign cap_trig[t] = bus_we && (bus_addr == A_CAP);

    mct_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en_q[t]),
      .restart (periodic[t] && hit[t][0]),
      .cnt     (cnt[t])
    );

    mct_cmp_bank #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (en_q[t]),
      .cnt      (cnt[t]),
      .wdata    (bus_wdata),
      .match_we (match_we),
      .ier_we   (bus_we && bus_addr == A_IER),
      .clr_we   (bus_we && bus_addr == A_CLR),
      .match_q  (match[t]),
      .ier_q    (ier[t]),
      .status_q (status[t]),
      .hit      (hit[t]),
      .irq      (irq[t])
    );

    mct_capture #(.CNT_W(CNT_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (cap_trig[t]),
      .cnt       (cnt[t]),
      .cap_val   (cap_val[t]),
      .cap_valid (cap_valid[t])
    );
  end

  // single-cycle read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_ENABLE) bus_rdata = CNT_W'(en_q);
    if (bus_addr == A_FREE)   bus_rdata = CNT_W'(free_q);
    if (bus_addr == A_CAPV)   bus_rdata = CNT_W'(cap_valid);
    for (int t = 0; t < NUM_TMR; t++) begin
      if (bus_addr == ADDR_W'(ch_base(t) + CH_RESTART)) bus_rdata = CNT_W'(restart_q[t]);
      if (bus_addr == ADDR_W'(ch_base(t) + CH_IER))     bus_rdata = CNT_W'(ier[t]);
      if (bus_addr == ADDR_W'(ch_base(t) + CH_STATUS))  bus_rdata = CNT_W'(status[t]);
      if (bus_addr == ADDR_W'(ch_base(t) + CH_CAPTURE)) bus_rdata = cap_val[t];
      for (int c = 0; c < NUM_CMP; c++) begin
        if (bus_addr == ADDR_W'(ch_base(t) + CH_MATCH0 + c)) bus_rdata = match[t][c];
      end
    end
  end
endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk #(
  parameter int NUM_TMR = 3,
  parameter int NUM_CMP = 3,
  parameter int CNT_W   = 32
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_TMR-1:0]                en_q,
  input logic [NUM_TMR-1:0]                periodic,
  input logic [NUM_TMR-1:0][CNT_W-1:0]     cnt,
  input logic [NUM_TMR-1:0][NUM_CMP-1:0]   hit,
  input logic [NUM_TMR-1:0][NUM_CMP-1:0]   status,
  input logic [NUM_TMR-1:0]                cap_trig,
  input logic [NUM_TMR-1:0]                cap_valid
);
  for (genvar t = 0; t < NUM_TMR; t++) begin : g_t
    // R2
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[t] |=> (cnt[t] == '0));
    // R4
    periodic_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (periodic[t] && hit[t][0]) |=> (cnt[t] == '0));
    // R5
    free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[t] && !periodic[t] && cnt[t] == '1) |=> (cnt[t] == '0));
    // R8
    capvalid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_valid[t]) |-> $past(cap_trig[t], 2));
    for (genvar c = 0; c < NUM_CMP; c++) begin : g_c
      // R6
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit[t][c] |=> status[t][c]);
      // R6
      rise_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[t][c]) |-> $past(hit[t][c]));
    end
  end
endmodule

bind mct_timer mct_timer_chk #(
  .NUM_TMR (NUM_TMR),
  .NUM_CMP (NUM_CMP),
  .CNT_W   (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_q      (en_q),
  .periodic  (periodic),
  .cnt       (cnt),
  .hit       (hit),
  .status    (status),
  .cap_trig  (cap_trig),
  .cap_valid (cap_valid)
);

// File: tb/mct_timer_tb_top.sv
module mct_timer_tb_top;
  localparam int NT = 3;
  localparam int NC = 3;
  localparam int W  = 8;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [W-1:0]  bus_rdata;
  logic [NT-1:0] irq;

  int  errors = 0;
  int  checks = 0;
  bit  run_chk = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  mct_timer #(.NUM_TMR(NT), .NUM_CMP(NC), .CNT_W(W), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  logic [W-1:0] m_cnt [NT];
  logic [W-1:0] m_match [NT][NC];
  logic [W-1:0] m_cap1 [NT];
  logic [W-1:0] m_cap2 [NT];
  bit           m_en [NT], m_free [NT], m_rst [NT], m_v1 [NT], m_v2 [NT];
  bit [NC-1:0]  m_ier [NT], m_st [NT];

  function automatic int base(input int t);
    return 16 * (t + 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) begin
        m_cnt[t] = 0; m_cap1[t] = 0; m_cap2[t] = 0;
        m_en[t] = 0; m_free[t] = 0; m_rst[t] = 0; m_v1[t] = 0; m_v2[t] = 0;
        m_ier[t] = 0; m_st[t] = 0;
        for (int c = 0; c < NC; c++) m_match[t][c] = '1;
      end
    end else begin
      for (int t = 0; t < NT; t++) begin
        bit [NC-1:0] h;
        bit [NC-1:0] clr;
        bit trig;
        for (int c = 0; c < NC; c++) h[c] = m_en[t] && (m_cnt[t] == m_match[t][c]);
        trig = bus_we && (int'(bus_addr) == base(t) + 3);
        clr  = (bus_we && int'(bus_addr) == base(t) + 2) ? bus_wdata[NC-1:0] : '0;
        if (m_v1[t]) begin m_cap2[t] = m_cap1[t]; m_v2[t] = 1; end
        if (trig) m_v2[t] = 0;
        m_v1[t] = trig;
        if (trig) m_cap1[t] = m_cnt[t];
        m_st[t] = (m_st[t] & ~clr) | h;
        if (!m_en[t] || (m_rst[t] && !m_free[t] && h[0])) m_cnt[t] = 0;
        else m_cnt[t] = m_cnt[t] + 8'd1;
      end
      if (bus_we) begin
        if (bus_addr == 0) for (int t = 0; t < NT; t++) m_en[t] = bus_wdata[t];
        if (bus_addr == 1) for (int t = 0; t < NT; t++) m_free[t] = bus_wdata[t];
        for (int t = 0; t < NT; t++) begin
          if (int'(bus_addr) == base(t))     m_rst[t] = bus_wdata[0];
          if (int'(bus_addr) == base(t) + 1) m_ier[t] = bus_wdata[NC-1:0];
          for (int c = 0; c < NC; c++)
            if (int'(bus_addr) == base(t) + 4 + c) m_match[t][c] = bus_wdata;
        end
      end
    end
  end

  function automatic logic [W-1:0] m_read(input int a);
    logic [W-1:0] r = 0;
    for (int t = 0; t < NT; t++) begin
      if (a == 0) r[t] = m_en[t];
      if (a == 1) r[t] = m_free[t];
      if (a == 2) r[t] = m_v2[t];
      if (a == base(t))     r = W'(m_rst[t]);
      if (a == base(t) + 1) r = W'(m_ier[t]);
      if (a == base(t) + 2) r = W'(m_st[t]);
      if (a == base(t) + 3) r = m_cap2[t];
      for (int c = 0; c < NC; c++) if (a == base(t) + 4 + c) r = m_match[t][c];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R7 every-clock interrupt comparison
  always @(negedge clk) begin
    if (rst_n && run_chk)
      for (int t = 0; t < NT; t++)
        chk("R7 irq vs model", 32'(irq[t]), 32'(|(m_st[t] & m_ier[t])));
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = W'(d); bus_we = 1'b1;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = AW'(a);
    #1 chk(tag, 32'(bus_rdata), 32'(m_read(a)));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_chk = 1;

    // R1 reset state
    chk("R1 irq low", 32'(irq), 0);
    rd(0, "R1 enable"); rd(1, "R1 override"); rd(2, "R1 capvalid");
    for (int t = 0; t < NT; t++)
      for (int o = 0; o < 4 + NC; o++) rd(base(t) + o, "R1 timer regs");
    @(negedge clk); bus_addr = AW'(base(0) + 4); #1 chk("R1 match all-ones", 32'(bus_rdata), 32'hFF);

    // R3 match N-1 fires after N edges
    wr(base(0) + 4, 4);
    wr(base(0) + 1, 1);
    wr(0, 1);
    for (int k = 0; k < 5; k++) begin @(negedge clk); chk("R3 before match", 32'(irq[0]), 0); end
    @(negedge clk); chk("R3 match fires", 32'(irq[0]), 1);

    // R6 clear, then R4 periodic with clears on every phase
    rd(base(0) + 2, "R6 status set");
    wr(base(0) + 2, 1);
    rd(base(0) + 2, "R6 status cleared");
    wr(0, 0);
    wr(base(0), 1);
    wr(0, 1);
    for (int i = 0; i < 10; i++) begin
      wr(base(0) + 2, 1);
      rd(base(0) + 2, "R6 clear vs match");
    end
    for (int i = 0; i < 8; i++) begin
      wr(base(0) + 3, i);
      rd(2, "R8 capvalid low after trigger");
      rd(base(0) + 3, "R4 R8 captured count");
      rd(2, "R8 capvalid high");
    end

    // R5 free-running timer 1, wrap matches at 0xFF and 0x00
    wr(base(1) + 5, 8'hFF);
    wr(base(1) + 6, 8'h00);
    wr(base(1) + 1, 3'b110);
    wr(base(1), 1);
    wr(1, 3'b010);
    wr(0, 3'b011);
    for (int i = 0; i < 6; i++) begin
      idle(97);
      wr(base(1) + 3, 0);
      idle(1);
      rd(base(1) + 3, "R5 capture free-run");
      rd(base(1) + 2, "R5 status");
      wr(base(1) + 2, 3'b111);
    end

    // R10 timer 2 periodic alongside others
    wr(base(2) + 4, 2);
    wr(base(2) + 1, 1);
    wr(base(2), 1);
    wr(0, 3'b111);
    idle(20);
    rd(base(2) + 2, "R10 timer2 status");
    rd(base(0) + 2, "R10 timer0 status");
    // R7 mask: status stays set, irq low
    wr(base(2) + 1, 0);
    idle(5);
    rd(base(2) + 2, "R7 status under mask");
    @(negedge clk); chk("R7 masked irq low", 32'(irq[2]), 0);

    // R2 disable clears the count
    wr(0, 3'b101);
    idle(2);
    wr(base(1) + 3, 1);
    idle(2);
    rd(base(1) + 3, "R2 count after disable");
    chk("R2 captured zero", 32'(bus_rdata), 0);

    // R9 ignored writes and unmapped reads
    wr(2, 8'hFF);
    wr(8'h05, 8'hAA);
    wr(8'hF0, 1);
    wr(base(0) + 4 + NC, 8'h33);
    rd(2, "R9 capvalid unchanged");
    rd(0, "R9 enable unchanged");
    rd(1, "R9 override unchanged");
    rd(8'h05, "R9 unmapped");
    chk("R9 unmapped zero", 32'(bus_rdata), 0);
    rd(8'hF0, "R9 unmapped high");
    rd(base(0) + 4 + NC, "R9 unmapped in block");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule